// File: doc/BRIEF.md
# PWM Clock Prescaler and Scaler

This block derives the timebase strobes for a six-channel pulse-width modulator from the bus clock. A shared free-running prescale counter supplies two power-of-two prescaled strobes, A and B, each with its own 3-bit divide select. Two reloadable down-counters then divide A and B by an even factor to give the scaled strobes SA and SB. Every output is a one-cycle enable pulse in the bus-clock domain. It is not a separate clock net.

A per-channel source bit routes either the prescaled or the scaled strobe of that channel's side to the channel. Channels 0, 1, 4 and 5 sit on the A side and channels 2 and 3 on the B side. The prescale counter is held cleared, and all strobes stop, whenever the freeze gate is active or every channel enable is low. The period and duty counters of the channels are outside this block.

Top module: `pwm_clkgen`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge, and the prescale and scale counters return to zero.
- R2: While running, `tick_a_o` pulses once every 2^`pre_sel_a_i` cycles (select 0 gives a pulse every cycle, select 7 every 128 cycles). `tick_b_o` follows `pre_sel_b_i` in the same way. All outputs are registered, one cycle after the edge that sees the counter state.
- R3: The prescale counter is cleared while gated. The first prescaled pulse after running resumes is visible 2^select cycles after the first running edge.
- R4: The first SA pulse after reset coincides with the first A pulse. After that, SA pulses on every 2N-th A pulse, where N is `scale_a_i` and N = 0 means 256 (a divide by 512). SB derives from B and `scale_b_i` in the same way. SA never pulses without A, and SB never pulses without B.
- R5: A new scale value does not cut short the count in progress. It is loaded at the next terminal count.
- R6: When `freeze_en_i` and `freeze_mode_i` are both 1, no output pulses. `freeze_mode_i` alone has no effect.
- R7: When all six bits of `ch_en_i` are 0, no output pulses.
- R8: `ch_tick_o[i]` equals the scaled strobe of its side when `ch_src_sel_i[i]` is 1, and the prescaled strobe when it is 0. Channels 0, 1, 4 and 5 use A/SA, and channels 2 and 3 use B/SB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| freeze_mode_i | input | 1 | Device is in freeze mode |
| freeze_en_i | input | 1 | Allow freeze mode to stop the prescaler |
| ch_en_i | input | 6 | Channel enables; all zero gates the prescaler |
| pre_sel_a_i | input | 3 | Prescale select for A (divide by 2^value) |
| pre_sel_b_i | input | 3 | Prescale select for B (divide by 2^value) |
| scale_a_i | input | 8 | SA divide half-factor N (0 means 256) |
| scale_b_i | input | 8 | SB divide half-factor N (0 means 256) |
| ch_src_sel_i | input | 6 | Per-channel source: 1 selects scaled, 0 selects prescaled |
| tick_a_o | output | 1 | Prescaled strobe A |
| tick_b_o | output | 1 | Prescaled strobe B |
| tick_sa_o | output | 1 | Scaled strobe SA |
| tick_sb_o | output | 1 | Scaled strobe SB |
| ch_tick_o | output | 6 | Per-channel selected strobe |

## Verification
The bench builds the block at its default parameters: six channels, 3-bit prescale selects and 8-bit scale values. At these values the full 128-cycle prescale wrap and the 512-step divide for N = 0 can be reached within a short run. Random phases keep the prescale selects small and the scale values low, so that many SA/SB terminal counts, reloads taken in the middle of a count, and gate toggles happen in a few thousand cycles. Directed phases measure the extreme periods and the restart delay.

// File: rtl/pwm_clkgen_pkg.sv
package pwm_clkgen_pkg;
   localparam int PATHS  = 2;
   localparam int PATH_A = 0;
   localparam int PATH_B = 1;

   typedef enum logic {
      SRC_PRESCALED = 1'b0,
      SRC_SCALED    = 1'b1
   } src_sel_e;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
   import pwm_clkgen_pkg::*;
#(
   parameter int PRE_SEL_W = 3
) (
   input  logic                              clk,
   input  logic                              rst,
   input  logic                              run_i,
   input  logic [PATHS-1:0][PRE_SEL_W-1:0]   sel_i,
   output logic [PATHS-1:0]                  stb_o
);
   localparam int CNT_W = (1 << PRE_SEL_W) - 1;

   if (PRE_SEL_W < 1 || PRE_SEL_W > 5) begin : g_bad_w
      $error("pwm_prescaler: PRE_SEL_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || !run_i) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
   end

   for (genvar p = 0; p < PATHS; p++) begin : g_path
      logic [CNT_W-1:0] mask;
      assign mask     = ~({CNT_W{1'b1}} << sel_i[p]);
      assign stb_o[p] = run_i && ((cnt_q & mask) == mask);
   end
endmodule

// File: rtl/pwm_scaler.sv
module pwm_scaler #(
   parameter int SCALE_W = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               src_stb_i,
   input  logic [SCALE_W-1:0] scale_i,
   output logic               stb_o
);
   localparam int CNT_W = SCALE_W + 1;

   if (SCALE_W < 1 || SCALE_W > 16) begin : g_bad_w
      $error("pwm_scaler: SCALE_W out of range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;
   logic             at_term;

   assign reload  = (scale_i == '0) ? {CNT_W{1'b1}} : ({scale_i, 1'b0} - 1'b1);
   assign at_term = (cnt_q == '0);
   assign stb_o   = src_stb_i && at_term;

   always_ff @(posedge clk) begin
      if (rst)            cnt_q <= '0;
      else if (src_stb_i) cnt_q <= at_term ? reload : cnt_q - 1'b1;
   end
endmodule

// File: rtl/pwm_ch_mux.sv
module pwm_ch_mux
   import pwm_clkgen_pkg::*;
#(
   parameter int                 NUM_CH      = 6,
   parameter logic [NUM_CH-1:0]  A_SIDE_MASK = NUM_CH'(6'b110011)
) (
   input  logic [PATHS-1:0]  pre_stb_i,
   input  logic [PATHS-1:0]  scl_stb_i,
   input  logic [NUM_CH-1:0] sel_i,
   output logic [NUM_CH-1:0] ch_stb_o
);
   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      localparam int SIDE = A_SIDE_MASK[i] ? PATH_A : PATH_B;
      assign ch_stb_o[i] = (src_sel_e'(sel_i[i]) == SRC_SCALED) ? scl_stb_i[SIDE]
                                                                : pre_stb_i[SIDE];
   end
endmodule

// File: rtl/pwm_clkgen.sv
module pwm_clkgen
   import pwm_clkgen_pkg::*;
#(
   parameter int                NUM_CH      = 6,
   parameter int                PRE_SEL_W   = 3,
   parameter int                SCALE_W     = 8,
   parameter logic [NUM_CH-1:0] A_SIDE_MASK = NUM_CH'(6'b110011)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 freeze_mode_i,
   input  logic                 freeze_en_i,
   input  logic [NUM_CH-1:0]    ch_en_i,
   input  logic [PRE_SEL_W-1:0] pre_sel_a_i,
   input  logic [PRE_SEL_W-1:0] pre_sel_b_i,
   input  logic [SCALE_W-1:0]   scale_a_i,
   input  logic [SCALE_W-1:0]   scale_b_i,
   input  logic [NUM_CH-1:0]    ch_src_sel_i,
   output logic                 tick_a_o,
   output logic                 tick_b_o,
   output logic                 tick_sa_o,
   output logic                 tick_sb_o,
   output logic [NUM_CH-1:0]    ch_tick_o
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("pwm_clkgen: NUM_CH must be at least 1");
   end

   logic                             run;
   logic [PATHS-1:0][PRE_SEL_W-1:0]  pre_sel;
   logic [PATHS-1:0][SCALE_W-1:0]    scale;
   logic [PATHS-1:0]                 pre_stb;
   logic [PATHS-1:0]                 scl_stb;
   logic [NUM_CH-1:0]                ch_stb;

   assign run = (|ch_en_i) && !(freeze_en_i && freeze_mode_i);

   assign pre_sel[PATH_A] = pre_sel_a_i;
   assign pre_sel[PATH_B] = pre_sel_b_i;
   assign scale[PATH_A]   = scale_a_i;
   assign scale[PATH_B]   = scale_b_i;

   pwm_prescaler #(.PRE_SEL_W(PRE_SEL_W)) u_pre (
      .clk   (clk),
      .rst   (rst),
      .run_i (run),
      .sel_i (pre_sel),
      .stb_o (pre_stb)
   );

   for (genvar p = 0; p < PATHS; p++) begin : g_scl
      pwm_scaler #(.SCALE_W(SCALE_W)) u_scl (
         .clk       (clk),
         .rst       (rst),
         .src_stb_i (pre_stb[p]),
         .scale_i   (scale[p]),
         .stb_o     (scl_stb[p])
      );
   end

   pwm_ch_mux #(.NUM_CH(NUM_CH), .A_SIDE_MASK(A_SIDE_MASK)) u_mux (
      .pre_stb_i (pre_stb),
      .scl_stb_i (scl_stb),
      .sel_i     (ch_src_sel_i),
      .ch_stb_o  (ch_stb)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         tick_a_o  <= 1'b0;
         tick_b_o  <= 1'b0;
         tick_sa_o <= 1'b0;
         tick_sb_o <= 1'b0;
         ch_tick_o <= '0;
      end else begin
         tick_a_o  <= pre_stb[PATH_A];
         tick_b_o  <= pre_stb[PATH_B];
         tick_sa_o <= scl_stb[PATH_A];
         tick_sb_o <= scl_stb[PATH_B];
         ch_tick_o <= ch_stb;
      end
   end
endmodule

// File: rtl/pwm_clkgen_chk.sv
module pwm_clkgen_chk #(
   parameter int                NUM_CH      = 6,
   parameter logic [NUM_CH-1:0] A_SIDE_MASK = NUM_CH'(6'b110011)
) (
   input logic              clk,
   input logic              rst,
   input logic              freeze_mode_i,
   input logic              freeze_en_i,
   input logic [NUM_CH-1:0] ch_en_i,
   input logic [NUM_CH-1:0] ch_src_sel_i,
   input logic              tick_a_o,
   input logic              tick_b_o,
   input logic              tick_sa_o,
   input logic              tick_sb_o,
   input logic [NUM_CH-1:0] ch_tick_o
);
   p_reset_r1: assert property (@(posedge clk)
      rst |=> (!tick_a_o && !tick_b_o && !tick_sa_o && !tick_sb_o && ch_tick_o == '0));

   p_sa_sub_r4: assert property (@(posedge clk) disable iff (rst)
      tick_sa_o |-> tick_a_o);

   p_sb_sub_r4: assert property (@(posedge clk) disable iff (rst)
      tick_sb_o |-> tick_b_o);

   p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
      (freeze_en_i && freeze_mode_i) |=>
         (!tick_a_o && !tick_b_o && !tick_sa_o && !tick_sb_o && ch_tick_o == '0));

   p_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (ch_en_i == '0) |=>
         (!tick_a_o && !tick_b_o && !tick_sa_o && !tick_sb_o && ch_tick_o == '0));

   for (genvar i = 0; i < NUM_CH; i++) begin : g_route
      if (A_SIDE_MASK[i]) begin : g_a
         p_route_r8: assert property (@(posedge clk) disable iff (rst)
            ch_tick_o[i] == ($past(ch_src_sel_i[i]) ? tick_sa_o : tick_a_o));
      end else begin : g_b
         p_route_r8: assert property (@(posedge clk) disable iff (rst)
            ch_tick_o[i] == ($past(ch_src_sel_i[i]) ? tick_sb_o : tick_b_o));
      end
   end
endmodule

bind pwm_clkgen pwm_clkgen_chk #(.NUM_CH(NUM_CH), .A_SIDE_MASK(A_SIDE_MASK)) u_chk (
   .clk           (clk),
   .rst           (rst),
   .freeze_mode_i (freeze_mode_i),
   .freeze_en_i   (freeze_en_i),
   .ch_en_i       (ch_en_i),
   .ch_src_sel_i  (ch_src_sel_i),
   .tick_a_o      (tick_a_o),
   .tick_b_o      (tick_b_o),
   .tick_sa_o     (tick_sa_o),
   .tick_sb_o     (tick_sb_o),
   .ch_tick_o     (ch_tick_o)
);

// File: tb/pwm_clkgen_tb.sv
`timescale 1ns/1ps
module pwm_clkgen_tb;
   logic       clk = 1'b0;
   logic       rst;
   logic       freeze_mode_i, freeze_en_i;
   logic [5:0] ch_en_i, ch_src_sel_i;
   logic [2:0] pre_sel_a_i, pre_sel_b_i;
   logic [7:0] scale_a_i, scale_b_i;
   logic       tick_a_o, tick_b_o, tick_sa_o, tick_sb_o;
   logic [5:0] ch_tick_o;

   int n_chk = 0;
   int n_fail = 0;
   int m_cyc = 0;
   int m_left_a = 0;
   int m_left_b = 0;

   always #5 clk = ~clk;

   pwm_clkgen u_dut (.*);

   task automatic check(input logic ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic int half_to_div(input int n);
      return (n == 0) ? 512 : 2 * n;
   endfunction

   // one clock edge, compare all outputs with the reference expectation
   task automatic step();
      bit run, ea, eb, esa, esb;
      logic [5:0] ech;
      string gtag;
      run = (ch_en_i != 0) && !(freeze_en_i && freeze_mode_i);
      gtag = (ch_en_i == 0) ? "R7" : "R6";
      ea = !rst && run && ((m_cyc % (1 << pre_sel_a_i)) == (1 << pre_sel_a_i) - 1);
      eb = !rst && run && ((m_cyc % (1 << pre_sel_b_i)) == (1 << pre_sel_b_i) - 1);
      esa = ea && (m_left_a == 0);
      esb = eb && (m_left_b == 0);
      for (int i = 0; i < 6; i++) begin
         bit a_side = (i != 2 && i != 3);
         ech[i] = a_side ? (ch_src_sel_i[i] ? esa : ea) : (ch_src_sel_i[i] ? esb : eb);
      end
      @(posedge clk);
      #1;
      if (rst) begin
         check(tick_a_o == 0 && tick_b_o == 0 && tick_sa_o == 0 && tick_sb_o == 0 &&
               ch_tick_o == 0, "R1", {tick_a_o, tick_b_o, tick_sa_o, tick_sb_o, ch_tick_o}, 0);
         m_cyc = 0; m_left_a = 0; m_left_b = 0;
         return;
      end
      check(tick_a_o == ea, run ? "R2" : gtag, tick_a_o, ea);
      check(tick_b_o == eb, run ? "R2" : gtag, tick_b_o, eb);
      check(tick_sa_o == esa, run ? "R4" : gtag, tick_sa_o, esa);
      check(tick_sb_o == esb, run ? "R4" : gtag, tick_sb_o, esb);
      check(ch_tick_o == ech, run ? "R8" : gtag, ch_tick_o, ech);
      if (ea) m_left_a = (m_left_a == 0) ? half_to_div(scale_a_i) - 1 : m_left_a - 1;
      if (eb) m_left_b = (m_left_b == 0) ? half_to_div(scale_b_i) - 1 : m_left_b - 1;
      m_cyc = run ? (m_cyc + 1) % 128 : 0;
   endtask

   // steps until the chosen output pulses; n = steps taken
   task automatic wait_for(input int which, output int n);
      n = 0;
      for (int k = 0; k < 4000; k++) begin
         step();
         n++;
         if ((which == 0 && tick_a_o) || (which == 1 && tick_sa_o) ||
             (which == 2 && tick_b_o) || (which == 3 && tick_sb_o)) return;
      end
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      int unsigned seed;
      seed = $urandom(32'd2024);
      rst = 1; freeze_mode_i = 0; freeze_en_i = 0; ch_en_i = 6'h3F;
      ch_src_sel_i = 0; pre_sel_a_i = 0; pre_sel_b_i = 0; scale_a_i = 1; scale_b_i = 1;
      // R1: reset state
      repeat (3) step();
      rst = 0;

      // R2: divide by 1 pulses every cycle; R8 routing on prescaled sources
      repeat (8) step();

      // R3: restart delay, A select 3 -> first pulse 8 cycles after resume
      ch_en_i = 0; pre_sel_a_i = 3; pre_sel_b_i = 7;
      repeat (5) step();                 // R7 gated
      ch_en_i = 6'h04;
      wait_for(0, n);
      check(n == 8, "R3", n, 8);
      wait_for(0, n);
      check(n == 8, "R2", n, 8);         // divide by 8 period
      wait_for(2, n);
      check(n == 128 - 16, "R2", n, 112); // B select 7 wraps at 128 from resume

      // R4: N = 0 divides by 512; A at divide 1
      rst = 1; step(); rst = 0;
      pre_sel_a_i = 0; scale_a_i = 0; ch_src_sel_i = 6'h33;
      wait_for(1, n);
      check(n == 1, "R4", n, 1);         // first SA with first A after reset
      wait_for(1, n);
      check(n == 512, "R4", n, 512);
      // R5: new value taken only at next terminal count
      scale_a_i = 3;
      repeat (100) step();
      wait_for(1, n);
      check(n == 412, "R5", n, 412);
      wait_for(1, n);
      check(n == 6, "R5", n, 6);

      // R6: freeze mode alone does nothing; with enable it gates
      freeze_mode_i = 1; freeze_en_i = 0;
      wait_for(1, n);
      check(n == 6, "R6", n, 6);
      freeze_en_i = 1;
      repeat (20) step();
      check(tick_a_o == 0 && tick_sa_o == 0 && ch_tick_o == 0, "R6", tick_a_o, 0);
      freeze_mode_i = 0; freeze_en_i = 0;

      // random phases
      for (int ph = 0; ph < 30; ph++) begin
         pre_sel_a_i  = 3'($urandom_range(0, 3));
         pre_sel_b_i  = 3'($urandom_range(0, 3));
         scale_a_i    = 8'($urandom_range(0, 5));
         scale_b_i    = 8'($urandom_range(0, 5));
         ch_src_sel_i = 6'($urandom);
         ch_en_i      = ($urandom_range(0, 5) == 0) ? 6'h00 : 6'($urandom | 1);
         freeze_mode_i = 1'($urandom);
         freeze_en_i   = ($urandom_range(0, 3) == 0);
         repeat ($urandom_range(20, 150)) step();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule